// File: doc/BRIEF.md
# Serial Bit-Addressed I/O Transfer Controller

This block moves bits between a processor and a bit-addressed serial I/O space. It handles two kinds of command. A single-bit command adds a signed bit displacement to a base address, then drives one I/O line high or low, or samples one line into a status bit. A multi-bit command shifts between 1 and 16 bits, one per clock, between a memory operand and consecutive I/O lines that start at the base address.

The base address is taken from a 16-bit base register. The register's least significant bit is dropped and the next twelve bits are kept, so the base is the register value shifted right one place. The memory operand is supplied as a 16-bit value. A stored result is returned on a 16-bit output. A byte operand sits in the upper half of that 16-bit path. The caller issues a one-cycle start with a command code and then waits for the done pulse.

Top module: `bitio_xfer`

## Requirements
- R1: For single-bit commands, the line address is `baseReg[12:1]` plus the sign-extended 8-bit `disp`, taken modulo 4096. For example, `baseReg` = 0x0010 with `disp` = 5 selects line 13, and `baseReg` = 0x0020 with `disp` = 0xFD selects line 13.
- R2: Command code 0 drives the addressed line to one and code 1 drives it to zero. Each does this for one cycle, with `ioWe` high and `ioWdata` at the value. `ioWe` and `ioRead` are never high together.
- R3: Command code 2 raises `ioRead` for one cycle at the addressed line. `eqBit` then takes the sampled `ioRdata` and holds it until the next code-2 command.
- R4: For multi-bit commands, a `count` of 0 moves 16 bits and any other value moves `count` bits. Bit k uses line address `baseReg[12:1]` + k, taken modulo 4096.
- R5: For a `count` of 1 to 8 the operand is a byte, and operand bit k is `opData[8+k]`. Otherwise the operand is a word, and operand bit k is `opData[k]`. Bit numbering here has bit 0 as the least significant bit.
- R6: Command code 3 (load) drives operand bit k onto line base+k with `ioWe` high, least significant bit first.
- R7: Command code 4 (store) samples line base+k with `ioRead` high into operand bit k. On `storeData`, a byte result sits in bits 15:8 and bits 7:0 are zero. Operand bits at positions k ≥ count are zero.
- R8: A start seen at a clock edge while idle is accepted. Bit k is transferred during the (k+1)-th cycle after that edge. `done` is high for exactly the one cycle after the last bit. `busy` is high from the first bit cycle through the done cycle.
- R9: A start while `busy` is high is ignored. The running transfer continues unchanged and no second transfer follows.
- R10: A start with command code 5, 6 or 7 is ignored, and `busy` stays low.
- R11: After reset, `busy`, `done`, `ioWe`, `ioRead`, `eqBit` and `storeData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request, one cycle |
| cmd | input | 3 | Command code: 0 set, 1 clear, 2 test, 3 load, 4 store |
| baseReg | input | 16 | Base register value; bits 12:1 form the base line address |
| disp | input | 8 | Signed bit displacement for single-bit commands |
| count | input | 4 | Multi-bit count; 0 means 16 |
| opData | input | 16 | Memory operand for load |
| ioRdata | input | 1 | Value of the line at `ioAddr` |
| ioAddr | output | 12 | Line address of the current bit |
| ioWe | output | 1 | Line write strobe |
| ioWdata | output | 1 | Line write value |
| ioRead | output | 1 | Line sample strobe |
| busy | output | 1 | Transfer in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| eqBit | output | 1 | Result of the last test command |
| storeData | output | 16 | Gathered store operand |

## Verification
The assertions assume that `ioRdata` is a combinational function of `ioAddr` within the cycle. They also assume that a test command's sampled value is the one seen at the edge that ends its bit cycle. The bench keeps within these assumptions by modelling the I/O space as a bit array. The array is read combinationally and written only on `ioWe` at a clock edge. All inputs change only at the falling edge. `baseReg`, `disp`, `count` and `opData` are held at the start edge. After that the bench may change them, or pulse `start` with another code, to show that only the values captured at acceptance matter.

// File: rtl/bitio_pkg.sv
package bitio_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int IDX_W  = CNT_W + 1;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [2:0] {
    CMD_SET1  = 3'd0,
    CMD_SET0  = 3'd1,
    CMD_TEST  = 3'd2,
    CMD_LOAD  = 3'd3,
    CMD_STORE = 3'd4
  } cmd_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic             capture;   // latch operands this edge
    logic             single;    // single-bit command being captured
    logic             byteSel;   // byte-wide operand being captured
    logic             step;      // a bit moves this cycle
    logic             writeEn;   // drive the line
    logic             readEn;    // sample the line
    logic             forceEn;   // written value is a constant
    logic             forceBit;  // that constant
    logic             storeEn;   // gather sampled bit into operand
    logic             testEn;    // copy sampled bit into status
    logic [IDX_W-1:0] idx;       // bit index within the transfer
  } ctlStrobes_t;
endpackage

// File: rtl/bitio_ctrl.sv
module bitio_ctrl
  import bitio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        cmd,
  input  logic [CNT_W-1:0]  count,
  output ctlStrobes_t       ctl,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_FIN} state_e;

  state_e           state;
  cmd_e             cmdQ;
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] lastQ;
  logic [IDX_W-1:0] lastIdx;
  logic             cmdOk;
  logic             isSingle;
  logic             accept;

  assign cmdOk    = (cmd <= 3'(CMD_STORE));
  assign isSingle = (cmd <= 3'(CMD_TEST));
  assign accept   = start && (state == ST_IDLE) && cmdOk;

  always_comb begin
    if (isSingle)
      lastIdx = '0;
    else if (count == '0)
      lastIdx = IDX_W'(WORD_W - 1);
    else
      lastIdx = IDX_W'(count) - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cmdQ  <= CMD_SET1;
      idxQ  <= '0;
      lastQ <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_XFER;
          cmdQ  <= cmd_e'(cmd);
          idxQ  <= '0;
          lastQ <= lastIdx;
        end
        ST_XFER: begin
          idxQ <= idxQ + 1'b1;
          if (idxQ == lastQ) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.capture  = accept;
    ctl.single   = isSingle;
    ctl.byteSel  = !isSingle && (count != '0) && (int'(count) <= HALF_W);
    ctl.step     = (state == ST_XFER);
    ctl.writeEn  = ctl.step && (cmdQ == CMD_SET1 || cmdQ == CMD_SET0 || cmdQ == CMD_LOAD);
    ctl.readEn   = ctl.step && (cmdQ == CMD_TEST || cmdQ == CMD_STORE);
    ctl.forceEn  = (cmdQ != CMD_LOAD);
    ctl.forceBit = (cmdQ == CMD_SET1);
    ctl.storeEn  = ctl.step && (cmdQ == CMD_STORE);
    ctl.testEn   = ctl.step && (cmdQ == CMD_TEST);
    ctl.idx      = idxQ;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: a request during a transfer does not disturb the latched command
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(cmdQ));

  // R10: unknown command codes never start a transfer
  assert_bad_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && cmd > 3'(CMD_STORE)) |=> !busy);
endmodule

// File: rtl/bitio_dp.sv
module bitio_dp
  import bitio_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DISP_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic [WORD_W-1:0]  baseReg,
  input  logic [DISP_W-1:0]  disp,
  input  logic [WORD_W-1:0]  opData,
  input  logic               ioRdata,
  output logic [ADDR_W-1:0]  ioAddr,
  output logic               ioWe,
  output logic               ioWdata,
  output logic               ioRead,
  output logic               eqBit,
  output logic [WORD_W-1:0]  storeData
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] baseBits;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] shQ;
  logic [WORD_W-1:0] accQ;
  logic              byteQ;
  logic              eqQ;

  assign baseBits = baseReg[ADDR_W:1];
  assign dispExt  = {{EXT_W{disp[DISP_W-1]}}, disp};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      shQ   <= '0;
      accQ  <= '0;
      byteQ <= 1'b0;
      eqQ   <= 1'b0;
    end else if (ctl.capture) begin
      addrQ <= ctl.single ? (baseBits + dispExt) : baseBits;
      shQ   <= ctl.byteSel ? {{HALF_W{1'b0}}, opData[WORD_W-1:HALF_W]} : opData;
      accQ  <= '0;
      byteQ <= ctl.byteSel;
    end else if (ctl.step) begin
      addrQ <= addrQ + 1'b1;
      shQ   <= shQ >> 1;
      if (ctl.storeEn) accQ[ctl.idx[CNT_W-1:0]] <= ioRdata;
      if (ctl.testEn)  eqQ <= ioRdata;
    end
  end

  assign ioAddr  = addrQ;
  assign ioWe    = ctl.writeEn;
  assign ioRead  = ctl.readEn;
  assign ioWdata = ctl.forceEn ? ctl.forceBit : shQ[0];
  assign eqBit   = eqQ;

  // Result placement: byte results occupy the upper half
  for (genvar i = 0; i < WORD_W; i++) begin : g_place
    if (i >= HALF_W) begin : g_hi
      assign storeData[i] = byteQ ? accQ[i-HALF_W] : accQ[i];
    end else begin : g_lo
      assign storeData[i] = byteQ ? 1'b0 : accQ[i];
    end
  end

  // R4: consecutive bits walk up the line address space
  assert_addr_walk_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> ioAddr == $past(ioAddr) + 1'b1);

  // R2: the line is never driven and sampled in one cycle
  assert_we_read_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(ioWe && ioRead));

  // R3: status captures the line seen during the test cycle
  assert_test_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.testEn |=> eqBit == $past(ioRdata));
endmodule

// File: rtl/bitio_xfer.sv
module bitio_xfer
  import bitio_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DISP_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [2:0]         cmd,
  input  logic [WORD_W-1:0]  baseReg,
  input  logic [DISP_W-1:0]  disp,
  input  logic [CNT_W-1:0]   count,
  input  logic [WORD_W-1:0]  opData,
  input  logic               ioRdata,
  output logic [ADDR_W-1:0]  ioAddr,
  output logic               ioWe,
  output logic               ioWdata,
  output logic               ioRead,
  output logic               busy,
  output logic               done,
  output logic               eqBit,
  output logic [WORD_W-1:0]  storeData
);
  ctlStrobes_t ctl;

  bitio_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .cmd   (cmd),
    .count (count),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  bitio_dp #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .baseReg   (baseReg),
    .disp      (disp),
    .opData    (opData),
    .ioRdata   (ioRdata),
    .ioAddr    (ioAddr),
    .ioWe      (ioWe),
    .ioWdata   (ioWdata),
    .ioRead    (ioRead),
    .eqBit     (eqBit),
    .storeData (storeData)
  );
endmodule

// File: tb/sim_bitio_xfer.sv
`timescale 1ns/1ps
module sim_bitio_xfer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cmd = '0;
  logic [15:0] baseReg = '0;
  logic [7:0]  disp = '0;
  logic [3:0]  count = '0;
  logic [15:0] opData = '0;
  logic        ioRdata;
  logic [11:0] ioAddr;
  logic        ioWe, ioWdata, ioRead, busy, done, eqBit;
  logic [15:0] storeData;

  logic [4095:0] space = '0;
  int checks = 0;
  int errors = 0;
  logic prevEq = 1'b0;

  always #4 clk = ~clk;

  assign ioRdata = space[ioAddr];
  always @(posedge clk) if (ioWe) space[ioAddr] <= ioWdata;

  bitio_xfer u0 (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .baseReg(baseReg),
    .disp(disp), .count(count), .opData(opData), .ioRdata(ioRdata),
    .ioAddr(ioAddr), .ioWe(ioWe), .ioWdata(ioWdata), .ioRead(ioRead),
    .busy(busy), .done(done), .eqBit(eqBit), .storeData(storeData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference: one command, compared on every cycle of its life
  task automatic run(input int code, input logic [15:0] base, input logic [7:0] dsp,
                     input logic [3:0] cnt, input logic [15:0] data, input bit poke);
    int n;
    bit single, byteOp, wr, rd;
    logic [11:0] a0, ak;
    logic [15:0] expStore;
    logic expEq, expBit;
    single = (code < 3);
    n      = single ? 1 : (cnt == 0 ? 16 : int'(cnt));
    byteOp = !single && cnt != 0 && cnt <= 8;
    a0     = base[12:1] + (single ? {{4{dsp[7]}}, dsp} : 12'd0);
    wr     = (code == 0 || code == 1 || code == 3);
    rd     = (code == 2 || code == 4);
    expStore = '0;
    for (int k = 0; k < n; k++) begin
      ak = a0 + 12'(k);
      if (byteOp) expStore[8+k] = space[ak]; else expStore[k] = space[ak];
    end
    expEq = (code == 2) ? space[a0] : prevEq;
    cmd = 3'(code); baseReg = base; disp = dsp; count = cnt; opData = data; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    baseReg = 16'hFFFF; opData = ~data;
    for (int k = 0; k < n; k++) begin
      if (poke && k == 1) begin start = 1'b1; cmd = 3'd0; end else start = 1'b0;
      chk("R8 busy during bit", busy, 1);
      chk("R8 done low during bit", done, 0);
      chk(single ? "R1 line address" : "R4 line address", ioAddr, a0 + 12'(k));
      chk("R2 write strobe", ioWe, wr);
      chk("R7 read strobe", ioRead, rd);
      if (wr) begin
        if (code == 0) expBit = 1'b1;
        else if (code == 1) expBit = 1'b0;
        else expBit = byteOp ? data[8+k] : data[k];
        chk(code == 3 ? "R6/R5 load bit" : "R2 set value", ioWdata, expBit);
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R8 done pulse", done, 1);
    chk("R8 busy in done cycle", busy, 1);
    if (code == 4) chk("R7 store result", storeData, expStore);
    chk("R3 eqBit", eqBit, expEq);
    prevEq = expEq;
    @(negedge clk);
    chk("R8 done falls", done, 0);
    chk(poke ? "R9 no second transfer" : "R8 idle after done", busy, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 ioWe", ioWe, 0);
    chk("R11 ioRead", ioRead, 0);
    chk("R11 eqBit", eqBit, 0);
    chk("R11 storeData", storeData, 0);
    rstN = 1'b1;
    @(negedge clk);
    run(0, 16'h0010, 8'd5,   4'd0, 16'h0, 0);   // R1 line 13 set
    chk("R2 line 13 set", space[13], 1);
    run(2, 16'h0010, 8'd5,   4'd0, 16'h0, 0);   // R3 test reads 1
    run(1, 16'h0020, 8'hFD,  4'd0, 16'h0, 0);   // R1 negative disp, clear
    chk("R2 line 13 cleared", space[13], 0);
    run(2, 16'h0020, 8'hFD,  4'd0, 16'h0, 0);   // R3 test reads 0
    run(0, 16'h0000, 8'h80,  4'd0, 16'h0, 0);   // R1 wrap to 3968
    chk("R1 wrap line set", space[3968], 1);
    run(3, 16'h0200, 8'h00,  4'd0, 16'hA5C3, 1); // R4 16 bits, R9 poke
    run(4, 16'h0200, 8'h00,  4'd0, 16'h0, 0);    // R7 word
    chk("R6 word round trip", storeData, 16'hA5C3);
    run(3, 16'h0400, 8'h00,  4'd8, 16'h5A77, 1); // R5 byte load
    run(4, 16'h0400, 8'h00,  4'd8, 16'h0, 0);
    chk("R5 byte round trip", storeData, 16'h5A00);
    run(4, 16'h0400, 8'h00,  4'd5, 16'h0, 0);    // R7 partial byte
    chk("R7 partial byte", storeData, 16'h1A00);
    run(4, 16'h0200, 8'h00,  4'd12, 16'h0, 0);   // R7 partial word
    chk("R7 partial word", storeData, 16'h05C3);
    run(3, 16'h0600, 8'h00,  4'd9, 16'h01FF, 0); // R5 nine bits is word
    run(4, 16'h0600, 8'h00,  4'd9, 16'h0, 0);
    chk("R5 nine-bit word", storeData, 16'h01FF);
    // R10: reserved code ignored
    cmd = 3'd6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy stays low", busy, 0);
    chk("R10 no write", ioWe, 0);
    @(negedge clk);
    chk("R10 no done", done, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule